// File: doc/BRIEF.md
# Mask Test Condition Code Unit

This unit produces the 2-bit condition code for two kinds of masked test. The first tests a data word against a 16-bit bit mask. The second checks a 32-bit value that has just received bytes selected by a 4-bit byte mask. A mode select picks the rule. Operands arrive with a valid strobe, and the code appears, registered, one clock later with its own valid.

The unit is meant to sit beside an execution pipeline. Only the code is computed here: the byte merge and the register write-back belong to the neighbouring datapath. In mixed cases the result depends on the most significant selected position. That position comes from a combinational leading-one encoder, so no result takes more than one cycle.

A reserved mode value is answered with code 0 and a one-cycle error pulse that travels with the result.

Top module: `mask_cc_unit`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous clock. While reset is held, `out_valid`, `out_cc` and `out_err` are all 0.
- R2: In both test modes the selection is `in_data[15:0] & in_mask`, and `in_data[63:16]` has no effect. The code is 0 when the selection is zero or the mask is zero.
- R3: In both test modes, with a nonzero mask, the code is 3 when the selection equals the mask.
- R4: In the wide test mode, a mixed selection (nonzero, not equal to the mask) gives code 2 when `in_data` is 1 at the highest set bit of `in_mask`, and code 1 when it is 0.
- R5: In the narrow test mode a mixed selection always gives code 1, so this mode never produces code 2.
- R6: In insert mode the value is `in_data[31:0]` and the byte mask is `in_mask[3:0]`, where bit k selects byte k (bits 8k+7..8k). `in_mask[15:4]` has no effect. With a byte mask of 4'b1111 the code is 0 for a zero value, 1 when bit 31 is set, and 2 otherwise.
- R7: In insert mode with any other byte mask, the code is 0 when the value or the byte mask is zero. Otherwise k is the highest set byte-mask bit, and the code is 1 when value bit 8k+7 is set and 2 when it is clear.
- R8: Modes are encoded as 0 = narrow test, 1 = wide test, 2 = insert. Mode 3 gives code 0 with `out_err` high, for that one result cycle only. Valid modes never raise `out_err`.
- R9: In a cycle after `in_valid` was low, `out_cc` keeps its last value and `out_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| in_mode | input | 2 | 0 narrow test, 1 wide test, 2 insert, 3 reserved |
| in_data | input | 64 | Data word, or the value after insertion in bits 31..0 |
| in_mask | input | 16 | Bit mask for test modes; bits 3..0 are the byte mask in insert mode |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| out_cc | output | 2 | Condition code |
| out_err | output | 1 | Reserved mode was presented |

## Verification
Two rules can match the same operand pair, and the precedence between them decides the answer. A zero mask also makes the selection equal to the mask, so it could satisfy both the zero rule and the all-ones rule. Likewise, a full byte mask falls under both the sign-of-bit-31 rule and the leading-byte rule. The bench presents exactly these overlaps: zero masks in both test modes, a full byte mask with values whose only nonzero bits lie in low bytes, and an all-ones selection whose top data bit is set. It compares each against an independent model that applies the stated order: zero first, then all-ones, then the leading-bit rule. The error pulse shares its cycle with a valid result. Reserved-mode operands are interleaved back to back with valid ones, and both `out_cc` and `out_err` are judged in that same cycle.

// File: rtl/mcc_pkg.sv
`timescale 1ns/1ps
package mcc_pkg;

   typedef enum logic [1:0] {
      MCC_TM_NARROW = 2'd0,
      MCC_TM_WIDE   = 2'd1,
      MCC_INSERT    = 2'd2,
      MCC_RSVD      = 2'd3
   } mcc_mode_e;

   typedef logic [1:0] mcc_code_t;

   localparam mcc_code_t CC_ZERO  = 2'd0;
   localparam mcc_code_t CC_LOW   = 2'd1;
   localparam mcc_code_t CC_HIGH  = 2'd2;
   localparam mcc_code_t CC_ALL   = 2'd3;

endpackage

// File: rtl/mcc_lead_one.sv
`timescale 1ns/1ps
// Combinational leading-one encoder: index of the most significant set bit.
module mcc_lead_one #(
   parameter int W     = 16,
   localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     vec,
   output logic [IDX_W-1:0] idx,
   output logic             found
);

   generate
      if (W < 1) begin : g_bad_width
         $error("mcc_lead_one: W must be at least 1");
      end
   endgenerate

   always_comb begin
      idx   = '0;
      found = 1'b0;
      // Ascending scan: the last hit, the highest bit, wins.
      for (int i = 0; i < W; i++) begin
         if (vec[i]) begin
            idx   = IDX_W'(i);
            found = 1'b1;
         end
      end
   end

endmodule

// File: rtl/mcc_tm_eval.sv
`timescale 1ns/1ps
// Condition code for the bit-mask test modes.
module mcc_tm_eval
   import mcc_pkg::*;
#(
   parameter int MASK_W = 16
) (
   input  logic [MASK_W-1:0] data,
   input  logic [MASK_W-1:0] mask,
   input  logic              wide,
   output mcc_code_t         code
);

   localparam int IDX_W = (MASK_W > 1) ? $clog2(MASK_W) : 1;

   logic [MASK_W-1:0] sel;
   logic [IDX_W-1:0]  top_idx;
   logic              mask_nz;
   logic              top_bit;

   assign sel = data & mask;

   mcc_lead_one #(.W(MASK_W)) u_lead (
      .vec   (mask),
      .idx   (top_idx),
      .found (mask_nz)
   );

   assign top_bit = data[top_idx];

   always_comb begin
      if (!mask_nz || (sel == '0)) begin
         code = CC_ZERO;
      end else if (sel == mask) begin
         code = CC_ALL;
      end else if (wide && top_bit) begin
         code = CC_HIGH;
      end else begin
         code = CC_LOW;
      end
   end

endmodule

// File: rtl/mcc_icm_eval.sv
`timescale 1ns/1ps
// Condition code for the insert-under-byte-mask mode.
module mcc_icm_eval
   import mcc_pkg::*;
#(
   parameter int VAL_W = 32,
   localparam int BYTES = VAL_W / 8
) (
   input  logic [VAL_W-1:0] value,
   input  logic [BYTES-1:0] bmask,
   output mcc_code_t        code
);

   localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;

   generate
      if ((VAL_W % 8) != 0 || VAL_W < 8) begin : g_bad_width
         $error("mcc_icm_eval: VAL_W must be a positive multiple of 8");
      end
   endgenerate

   logic [BYTES-1:0] signs;
   logic [IDX_W-1:0] top_byte;
   logic             bmask_nz;

   generate
      for (genvar b = 0; b < BYTES; b++) begin : g_sign
         assign signs[b] = value[8*b+7];
      end
   endgenerate

   mcc_lead_one #(.W(BYTES)) u_lead (
      .vec   (bmask),
      .idx   (top_byte),
      .found (bmask_nz)
   );

   always_comb begin
      if (&bmask) begin
         if (value == '0)               code = CC_ZERO;
         else if (value[VAL_W-1])       code = CC_LOW;
         else                           code = CC_HIGH;
      end else if (!bmask_nz || (value == '0)) begin
         code = CC_ZERO;
      end else if (signs[top_byte]) begin
         code = CC_LOW;
      end else begin
         code = CC_HIGH;
      end
   end

endmodule

// File: rtl/mask_cc_unit.sv
`timescale 1ns/1ps
module mask_cc_unit
   import mcc_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int MASK_W = 16,
   parameter int INS_W  = 32,
   localparam int BYTES = INS_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        in_mode,
   input  logic [DATA_W-1:0] in_data,
   input  logic [MASK_W-1:0] in_mask,
   output logic              out_valid,
   output logic [1:0]        out_cc,
   output logic              out_err
);

   generate
      if (INS_W > DATA_W) begin : g_chk_ins
         $error("mask_cc_unit: INS_W exceeds DATA_W");
      end
      if (MASK_W > DATA_W) begin : g_chk_mask
         $error("mask_cc_unit: MASK_W exceeds DATA_W");
      end
      if (BYTES > MASK_W) begin : g_chk_bytes
         $error("mask_cc_unit: byte mask wider than mask port");
      end
   endgenerate

   // Bits above both operand fields are accepted but play no part.
   localparam int USED_W = (INS_W > MASK_W) ? INS_W : MASK_W;
   generate
      if (DATA_W > USED_W) begin : g_hi
         logic unused_hi_bits;
         assign unused_hi_bits = ^in_data[DATA_W-1:USED_W];
      end
   endgenerate

   mcc_code_t tm_code;
   mcc_code_t icm_code;
   mcc_code_t nxt_code;
   logic      nxt_err;
   mcc_mode_e mode;

   assign mode = mcc_mode_e'(in_mode);

   mcc_tm_eval #(.MASK_W(MASK_W)) u_tm (
      .data (in_data[MASK_W-1:0]),
      .mask (in_mask),
      .wide (mode == MCC_TM_WIDE),
      .code (tm_code)
   );

   mcc_icm_eval #(.VAL_W(INS_W)) u_icm (
      .value (in_data[INS_W-1:0]),
      .bmask (in_mask[BYTES-1:0]),
      .code  (icm_code)
   );

   always_comb begin
      nxt_err = 1'b0;
      unique case (mode)
         MCC_TM_NARROW,
         MCC_TM_WIDE:   nxt_code = tm_code;
         MCC_INSERT:    nxt_code = icm_code;
         default: begin
            nxt_code = CC_ZERO;
            nxt_err  = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_cc    <= CC_ZERO;
         out_err   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_err   <= in_valid & nxt_err;
         if (in_valid) begin
            out_cc <= nxt_code;
         end
      end
   end

endmodule

// File: rtl/mcc_checker.sv
`timescale 1ns/1ps
module mcc_checker #(
   parameter int MASK_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [1:0]        in_mode,
   input logic [MASK_W-1:0] in_mask,
   input logic              out_valid,
   input logic [1:0]        out_cc,
   input logic              out_err
);

   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   a_r2_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_mode[1] && in_mask == '0) |=> (out_cc == 2'd0));

   a_r5_narrow_no_high: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == 2'd0) |=> (out_cc != 2'd2));

   a_r7_insert_no_all: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == 2'd2) |=> (out_cc != 2'd3));

   a_r8_rsvd_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == 2'd3) |=> (out_err && out_cc == 2'd0));

   a_r8_no_false_err: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode != 2'd3) |=> !out_err);

   a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_cc) && !out_err));

endmodule

bind mask_cc_unit mcc_checker #(.MASK_W(MASK_W)) u_mcc_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_mode   (in_mode),
   .in_mask   (in_mask),
   .out_valid (out_valid),
   .out_cc    (out_cc),
   .out_err   (out_err)
);

// File: tb/mask_cc_unit_bench.sv
`timescale 1ns/1ps
module mask_cc_unit_bench;

   localparam int DW = 64;
   localparam int MW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [1:0]    in_mode = 2'd0;
   logic [DW-1:0] in_data = '0;
   logic [MW-1:0] in_mask = '0;
   logic          out_valid;
   logic [1:0]    out_cc;
   logic          out_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [1:0] cc;
      logic       err;
      string      req;
   } exp_t;

   exp_t exp_q[$];
   logic [1:0] last_cc = 2'd0;

   always #2.5 clk = ~clk;

   mask_cc_unit u_mask_cc_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_mode   (in_mode),
      .in_data   (in_data),
      .in_mask   (in_mask),
      .out_valid (out_valid),
      .out_cc    (out_cc),
      .out_err   (out_err)
   );

   // Reference model written from the requirements.
   function automatic void model(input logic [1:0] mode, input logic [DW-1:0] d,
                                 input logic [MW-1:0] m, output logic [1:0] cc,
                                 output logic err, output string req);
      logic [15:0] sel;
      logic [31:0] v;
      logic [3:0]  bm;
      int          top;
      err = 1'b0;
      cc  = 2'd0;
      top = -1;
      if (mode == 2'd0 || mode == 2'd1) begin
         sel = d[15:0] & m;
         for (int i = 15; i >= 0; i--) if (m[i] && top < 0) top = i;
         if (m == 16'd0 || sel == 16'd0) begin cc = 2'd0; req = "R2"; end
         else if (sel == m) begin cc = 2'd3; req = "R3"; end
         else if (mode == 2'd0) begin cc = 2'd1; req = "R5"; end
         else begin cc = d[top] ? 2'd2 : 2'd1; req = "R4"; end
      end else if (mode == 2'd2) begin
         v  = d[31:0];
         bm = m[3:0];
         for (int i = 3; i >= 0; i--) if (bm[i] && top < 0) top = i;
         if (bm == 4'hF) begin
            req = "R6";
            if (v == 32'd0) cc = 2'd0;
            else if (v[31]) cc = 2'd1;
            else cc = 2'd2;
         end else begin
            req = "R7";
            if (v == 32'd0 || bm == 4'd0) cc = 2'd0;
            else cc = v[8*top+7] ? 2'd1 : 2'd2;
         end
      end else begin
         cc = 2'd0; err = 1'b1; req = "R8";
      end
   endfunction

   task automatic send(input logic [1:0] mode, input logic [DW-1:0] d,
                       input logic [MW-1:0] m);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1;
      in_mode  = mode;
      in_data  = d;
      in_mask  = m;
      model(mode, d, m, e.cc, e.err, e.req);
      exp_q.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_data  = {$urandom, $urandom};
         in_mask  = MW'($urandom);
         in_mode  = 2'($urandom);
      end
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // Monitor: samples 1 ns after each rising edge.
   initial begin
      exp_t e;
      wait (rst_n);
      forever begin
         @(posedge clk);
         #1;
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R1", "unexpected out_valid", 1, 0);
            end else begin
               e = exp_q.pop_front();
               check(out_cc == e.cc, e.req, "out_cc", int'(out_cc), int'(e.cc));
               check(out_err == e.err, e.req == "R8" ? "R8" : "R8/no-err",
                     "out_err", int'(out_err), int'(e.err));
            end
            last_cc = out_cc;
         end else begin
            check(out_cc == last_cc, "R9", "out_cc hold", int'(out_cc), int'(last_cc));
            check(out_err == 1'b0, "R9", "out_err idle", int'(out_err), 0);
         end
      end
   end

   // Watchdog.
   initial begin
      #(150000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
      check(out_cc == 2'd0, "R1", "reset out_cc", int'(out_cc), 0);
      check(out_err == 1'b0, "R1", "reset out_err", int'(out_err), 0);
      rst_n = 1'b1;
      idle(2);

      // R2: zero mask, zero selection, high data bits ignored
      send(2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0000);
      send(2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0000);
      send(2'd1, 64'hFFFF_FFFF_FFFF_0000, 16'hFFFF);
      send(2'd0, 64'h1234_5678_9ABC_0F0F, 16'hF0F0);
      // R3: all selected ones, including top bit set
      send(2'd1, 64'h0000_0000_0000_8001, 16'h8001);
      send(2'd0, 64'h0000_0000_0000_FFFF, 16'hFFFF);
      // R4: wide mixed, top bit 1 and 0
      send(2'd1, 64'h0000_0000_0000_8000, 16'h8001);
      send(2'd1, 64'h0000_0000_0000_0030, 16'h00F0);
      send(2'd1, 64'hFFFF_0000_0000_0001, 16'h0003);
      // R5: narrow mixed
      send(2'd0, 64'h0000_0000_0000_8000, 16'h8001);
      send(2'd0, 64'h0000_0000_0000_0030, 16'h00F0);
      // R6: full byte mask, upper mask bits ignored
      send(2'd2, 64'h0000_0000_8000_0000, 16'h000F);
      send(2'd2, 64'h0000_0000_0000_0080, 16'h000F);
      send(2'd2, 64'hFFFF_FFFF_0000_0000, 16'hFFFF);
      // R7: partial byte masks
      send(2'd2, 64'h0000_0000_0080_0000, 16'h0005);
      send(2'd2, 64'h0000_0000_8000_0001, 16'h0003);
      send(2'd2, 64'h0000_0000_0000_0080, 16'h0000);
      send(2'd2, 64'h0000_0000_0000_0000, 16'h0004);
      send(2'd2, 64'h0000_0000_0000_0080, 16'hFFF1);
      // R8: reserved mode interleaved with valid ones
      send(2'd3, 64'h0000_0000_0000_FFFF, 16'hFFFF);
      send(2'd1, 64'h0000_0000_0000_FFFF, 16'hFFFF);
      send(2'd3, 64'h0000_0000_0000_0000, 16'h0000);
      // R9: idle gap after a nonzero code
      idle(4);
      send(2'd2, 64'h0000_0000_0000_0001, 16'h0001);
      idle(3);

      // Random mix with random gaps
      for (int n = 0; n < 3000; n++) begin
         logic [MW-1:0] rm;
         rm = MW'($urandom);
         if (($urandom % 4) == 0) rm = rm & MW'($urandom);
         send(2'($urandom), {$urandom, $urandom}, rm);
         if (($urandom % 5) == 0) idle(1 + ($urandom % 3));
      end
      idle(4);
      check(exp_q.size() == 0, "R1", "results outstanding", exp_q.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule